// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synchronous static memory whose bus can switch between read and write on every clock with no idle cycle. On each enabled rising edge it captures one command made of an address, a read/write flag, a load-or-advance flag, three chip selects and four lane write enables. The data for that command moves in the cycle that follows. Read data comes straight out of the array during that cycle, with no output register. Write data is taken on the next enabled edge and stored on that same edge.

A built-in four-beat burst sequencer lets one loaded address serve four words. It counts in either linear or interleaved order and wraps around inside the aligned group of four. A held-high clock enable freezes the whole block as if the edge had not happened. An asynchronous output enable can shut the read drivers at any time. The bidirectional data bus appears as three separate signals: write data in, read data out, and a per-bit drive enable. The 36-bit word holds four 9-bit lanes.

Top module: `zbt_sram_core`

## Requirements
- R1: A command is captured on a rising edge where `clk_en_n` is 0. The data for a read command appears on `rdata` in the cycle that directly follows that edge.
- R2: Reads are flow-through. In the cycle after a read edge, `rdata` shows the current array content of the pending address. A read issued on the edge that stores a write to the same word returns the new data.
- R3: A write command stores `wdata` on the next enabled edge. Only the lanes whose bit in `lane_en_n` was 0 when the command was captured are stored. Bit i of `lane_en_n` governs `wdata[9i+8:9i]`.
- R4: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load edge (`load_n`=0) without select starts a deselect: the bus is off in the next cycle and any burst stops. A write pending from the previous edge still completes.
- R5: An edge with `load_n`=1 and no burst in progress is a no-operation. `rdata_oe` is all zero in the next cycle.
- R6: An edge with `load_n`=1 during a burst moves to the next burst address. Whether the beat reads or writes is fixed at load, and `rd_wr_n` is ignored on advance edges. Only the two low address bits change. With `linear_order`=1 beat k uses low bits (base+k) mod 4; with 0 it uses base XOR k. After four beats the sequence wraps back to the base.
- R7: An edge with `clk_en_n`=1 changes no internal state, stores nothing, and leaves `rdata` and `rdata_oe` as they were.
- R8: `lane_en_n` has no effect on read commands. A read never modifies the array.
- R9: While `out_en_n` is 1, `rdata_oe` is all zero, independent of the clock.
- R10: After reset the pending operation is a no-operation and no burst is active. `rdata_oe` is 0 until a read has been loaded.
- R11: Read, write and read commands on consecutive edges each complete with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| load_n | input | 1 | 0 loads a new command, 1 advances a burst |
| rd_wr_n | input | 1 | 1 read, 0 write; sampled on load edges |
| lane_en_n | input | 4 | Active-low write enable per 9-bit lane |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| linear_order | input | 1 | 1 linear burst order, 0 interleaved |
| addr | input | ADDR_W | Word address, sampled on load edges |
| wdata | input | 36 | Write data, taken one enabled edge after the command |
| rdata | output | 36 | Read data; zero when not driving |
| rdata_oe | output | 36 | Per-bit drive enable for `rdata` |

## Verification
Some properties are checked on every cycle: a deselect or a no-operation turns the drivers off on the next cycle, a frozen edge leaves the pending command and its address unchanged, a high output enable blocks every driver, and a pending read never comes with a write strobe. The bench compares the block against its own shadow memory over mixed scenarios. Only those scenarios show that data values are right. They cover partially written lanes, both burst orders including wrap-around, a write that finishes through a deselect, a read that follows a write to the same word at once, and a freeze in the middle of a burst or with a write pending.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    OP_NOOP  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of burst beat `step` from `base`.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] base,
    input logic [BURST_BITS-1:0] step,
    input logic                  linear
  );
    logic [BURST_BITS-1:0] sum;
    sum = base + step;
    return linear ? sum : (base ^ step);
  endfunction
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop,
  input  logic              step,
  input  logic              linear,
  output logic              active,
  output logic              is_write,
  output logic [ADDR_W-1:0] next_addr
);
  import zbt_pkg::*;
  localparam int BB = BURST_BITS;

  logic              active_q;
  logic              kind_q;
  logic [ADDR_W-1:0] base_q;
  logic [BB-1:0]     cnt_q;
  logic [BB-1:0]     cnt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      kind_q   <= start_wr;
      base_q   <= start_addr;
      cnt_q    <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_nx;
    end
  end

  assign cnt_nx    = cnt_q + 1'b1;
  assign active    = active_q;
  assign is_write  = kind_q;
  assign next_addr = {base_q[ADDR_W-1:BB], burst_low(base_q[BB-1:0], cnt_nx, linear)};
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  zbt_pkg::op_e      nxt_op,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [LANES-1:0]  nxt_lanes,
  output zbt_pkg::op_e      op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_lanes,
  output logic              wr_fire
);
  import zbt_pkg::*;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NOOP;
      addr_q  <= '0;
      lanes_q <= '0;
    end else if (ce) begin
      op_q    <= nxt_op;
      addr_q  <= nxt_addr;
      lanes_q <= nxt_lanes;
    end
  end

  assign op       = op_q;
  assign op_addr  = addr_q;
  assign op_lanes = lanes_q;
  assign wr_fire  = ce && (op_q == OP_WRITE);
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LANES-1:0]         wmask,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [LANES*LANE_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic              load_n,
  input  logic              rd_wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              out_en_n,
  input  logic              linear_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] rdata_oe
);
  import zbt_pkg::*;

  logic              ce;
  logic              chip_sel;
  logic              seq_start;
  logic              seq_stop;
  logic              seq_step;
  logic              burst_active;
  logic              burst_wr;
  logic [ADDR_W-1:0] burst_addr;
  op_e               nxt_op;
  logic [ADDR_W-1:0] nxt_addr;
  logic [LANES-1:0]  nxt_lanes;
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_lanes;
  logic              wr_fire;
  logic [WORD_W-1:0] arr_rd;
  logic              drive;

  // Named internal events for the checker.
  logic [1:0]        pend_op_w;
  logic [ADDR_W-1:0] pend_addr_w;
  logic              wr_fire_w;
  logic              burst_active_w;

  assign ce        = !clk_en_n;
  assign chip_sel  = !sel_a_n && !sel_b_n && sel_c;
  assign seq_start = ce && !load_n && chip_sel;
  assign seq_stop  = ce && !load_n && !chip_sel;
  assign seq_step  = ce && load_n && burst_active;

  always_comb begin
    nxt_op    = OP_NOOP;
    nxt_addr  = pend_addr;
    nxt_lanes = '0;
    if (!load_n) begin
      if (chip_sel) begin
        nxt_op   = rd_wr_n ? OP_READ : OP_WRITE;
        nxt_addr = addr;
      end
    end else if (burst_active) begin
      nxt_op   = burst_wr ? OP_WRITE : OP_READ;
      nxt_addr = burst_addr;
    end
    if (nxt_op == OP_WRITE) nxt_lanes = ~lane_en_n;
  end

  zbt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (seq_start),
    .start_wr   (!rd_wr_n),
    .start_addr (addr),
    .stop       (seq_stop),
    .step       (seq_step),
    .linear     (linear_order),
    .active     (burst_active),
    .is_write   (burst_wr),
    .next_addr  (burst_addr)
  );

  zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .nxt_op    (nxt_op),
    .nxt_addr  (nxt_addr),
    .nxt_lanes (nxt_lanes),
    .op        (pend_op),
    .op_addr   (pend_addr),
    .op_lanes  (pend_lanes),
    .wr_fire   (wr_fire)
  );

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (pend_addr),
    .wmask (pend_lanes),
    .wdata (wdata),
    .raddr (pend_addr),
    .rdata (arr_rd)
  );

  assign drive    = (pend_op == OP_READ) && !out_en_n;
  assign rdata_oe = {WORD_W{drive}};
  assign rdata    = drive ? arr_rd : '0;

  assign pend_op_w      = pend_op;
  assign pend_addr_w    = pend_addr;
  assign wr_fire_w      = wr_fire;
  assign burst_active_w = burst_active;
endmodule

// File: rtl/zbt_sram_core_checks.sv
module zbt_sram_core_checks #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              load_n,
  input logic              rd_wr_n,
  input logic              out_en_n,
  input logic [WORD_W-1:0] rdata_oe,
  input logic [1:0]        pend_op_w,
  input logic [ADDR_W-1:0] pend_addr_w,
  input logic              wr_fire_w,
  input logic              burst_active_w
);
  import zbt_pkg::*;

  logic sel_ok;
  assign sel_ok = !sel_a_n && !sel_b_n && sel_c;

  a_r1_read_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && sel_ok && rd_wr_n) |=> (pend_op_w == OP_READ));

  a_r3_write_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && sel_ok && !rd_wr_n) |=> (pend_op_w == OP_WRITE));

  a_r4_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && !sel_ok) |=> (rdata_oe == '0));

  a_r5_noop_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && !burst_active_w) |=> (rdata_oe == '0));

  a_r6_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && burst_active_w) |=> (pend_op_w != OP_NOOP));

  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(pend_op_w) && $stable(pend_addr_w)));

  a_r8_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_op_w == OP_READ) |-> !wr_fire_w);

  a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (rdata_oe == '0));

  a_r10_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_op_w != OP_READ) |-> (rdata_oe == '0));
endmodule

bind zbt_sram_core zbt_sram_core_checks #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .clk_en_n       (clk_en_n),
  .sel_a_n        (sel_a_n),
  .sel_b_n        (sel_b_n),
  .sel_c          (sel_c),
  .load_n         (load_n),
  .rd_wr_n        (rd_wr_n),
  .out_en_n       (out_en_n),
  .rdata_oe       (rdata_oe),
  .pend_op_w      (pend_op_w),
  .pend_addr_w    (pend_addr_w),
  .wr_fire_w      (wr_fire_w),
  .burst_active_w (burst_active_w)
);

// File: tb/zbt_sram_core_test.sv
module zbt_sram_core_test;
  localparam int AW = 8;
  localparam int WW = 36;
  localparam logic [2:0] SEL = 3'b001;  // {sel_a_n, sel_b_n, sel_c}
  localparam logic [35:0] W0 = 36'h1_0203_0405, W1 = 36'h2_1122_3344,
                          W2 = 36'h3_5566_7788, W3 = 36'h4_99AA_BBCC,
                          W4 = 36'hF_FFFF_FFFF, W5 = 36'h0_1357_9BDF,
                          W6 = 36'h5_A5A5_5A5A, W7 = 36'hE_DEAD_BEEF,
                          W8 = 36'h6_C0DE_F00D, W9 = 36'h7_0BAD_CAFE;

  typedef struct packed {
    logic        cen_n;
    logic [2:0]  sel;
    logic        ld_n;
    logic        rw;
    logic [3:0]  ln;
    logic        oe_n;
    logic        lin;
    logic [7:0]  ad;
    logic [35:0] wd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, SEL,    1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h10, 36'h0, 4'd3},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, W0,    4'd6},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, W1,    4'd6},
    '{1'b0, SEL,    1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h00, W2,    4'd6},
    '{1'b0, SEL,    1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h20, W3,    4'd3},
    '{1'b0, SEL,    1'b0, 1'b0, 4'b1010, 1'b0, 1'b1, 8'h20, W4,    4'd3},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h20, W5,    4'd1},
    '{1'b0, SEL,    1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h30, 36'h0, 4'd11},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h30, W6,    4'd2},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h12, 36'h0, 4'd11},
    '{1'b0, SEL,    1'b1, 1'b0, 4'b1111, 1'b0, 1'b1, 8'h00, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd6},
    '{1'b1, SEL,    1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h55, W7,    4'd7},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd6},
    '{1'b0, 3'b011, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h10, 36'h0, 4'd4},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd5},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h11, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h00, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h00, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h00, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h00, 36'h0, 4'd6},
    '{1'b0, SEL,    1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h40, 36'h0, 4'd3},
    '{1'b0, 3'b000, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h00, W8,    4'd4},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h40, 36'h0, 4'd4},
    '{1'b0, SEL,    1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 8'h00, 36'h0, 4'd9},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h40, 36'h0, 4'd8},
    '{1'b0, SEL,    1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h40, W9,    4'd8}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cen_n, sa_n, sb_n, sc, ld_n, rw, oe_n, lin;
  logic [3:0]    ln;
  logic [AW-1:0] ad;
  logic [WW-1:0] wd;
  wire  [WW-1:0] rd, rdoe;

  zbt_sram_core #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(cen_n), .sel_a_n(sa_n), .sel_b_n(sb_n),
    .sel_c(sc), .load_n(ld_n), .rd_wr_n(rw), .lane_en_n(ln), .out_en_n(oe_n),
    .linear_order(lin), .addr(ad), .wdata(wd), .rdata(rd), .rdata_oe(rdoe)
  );

  int checks = 0;
  int errors = 0;

  // Shadow model, written from the requirements.
  logic [WW-1:0] smem [256];
  int            m_op;      // 0 none, 1 read, 2 write
  logic [AW-1:0] m_pa;
  logic [3:0]    m_pl;
  bit            m_act, m_kw;
  logic [AW-1:0] m_base;
  int            m_cnt;

  function automatic string tag(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, int k, bit linear);
    logic [AW-1:0] kk;
    kk = AW'(k);
    if (linear) return (base & ~AW'(3)) | ((base + kk) & AW'(3));
    return base ^ kk;
  endfunction

  task automatic m_reset();
    m_op = 0; m_act = 0; m_kw = 0; m_cnt = 0;
  endtask

  task automatic m_edge();
    if (cen_n) return;
    if (m_op == 2)
      for (int i = 0; i < 4; i++)
        if (!m_pl[i]) smem[m_pa][9*i +: 9] = wd[9*i +: 9];
    if (!ld_n) begin
      if (!sa_n && !sb_n && sc) begin
        m_op = rw ? 1 : 2; m_pa = ad; m_pl = ln;
        m_act = 1; m_kw = !rw; m_base = ad; m_cnt = 0;
      end else begin
        m_op = 0; m_act = 0;
      end
    end else if (m_act) begin
      m_cnt = (m_cnt + 1) % 4;
      m_op  = m_kw ? 2 : 1;
      m_pa  = beat_addr(m_base, m_cnt, lin);
      m_pl  = ln;
    end else begin
      m_op = 0;
    end
  endtask

  task automatic check_model(string t);
    logic [WW-1:0] e_oe, e_rd;
    e_oe = (m_op == 1 && !oe_n) ? '1 : '0;
    e_rd = (m_op == 1 && !oe_n) ? smem[m_pa] : '0;
    checks++;
    if (rdoe !== e_oe || rd !== e_rd) begin
      errors++;
      $display("FAIL %s oe=%h exp %h data=%h exp %h", t, rdoe, e_oe, rd, e_rd);
    end
  endtask

  task automatic expect_val(string t, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", t, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    cen_n = v.cen_n; {sa_n, sb_n, sc} = v.sel; ld_n = v.ld_n; rw = v.rw;
    ln = v.ln; oe_n = v.oe_n; lin = v.lin; ad = v.ad; wd = v.wd;
    @(posedge clk);
    m_edge();
    #2;
    check_model(tag(int'(v.req)));
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = '0;
    m_reset();
    rst_n = 1'b0; cen_n = 1'b0; {sa_n, sb_n, sc} = SEL; ld_n = 1'b1; rw = 1'b1;
    ln = 4'hF; oe_n = 1'b0; lin = 1'b1; ad = '0; wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_val("R10 reset oe", rdoe, '0);
    // R10: an advance right after reset has no burst to continue.
    apply('{1'b0, SEL, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd10});
    expect_val("R10 idle after reset", rdoe, '0);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R3: lanes 0 and 2 from W5, lanes 1 and 3 from W4.
    apply('{1'b0, SEL, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h20, 36'h0, 4'd3});
    expect_val("R3 partial lanes", rd,
               {W4[35:27], W5[26:18], W4[17:9], W5[8:0]});

    // R9: output enable acts without a clock edge.
    #1 oe_n = 1'b1;
    #1 expect_val("R9 async off", rdoe, '0);
    oe_n = 1'b0;
    #1 expect_val("R9 async on", rdoe, '1);

    // R7: freeze with a write pending; data is taken on the next enabled edge.
    apply('{1'b0, SEL, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h50, 36'h0, 4'd7});
    apply('{1'b1, SEL, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h51, W7,    4'd7});
    apply('{1'b0, SEL, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h50, W9,    4'd7});
    expect_val("R7 write after freeze", rd, W9);
    // R7: a frozen edge keeps the read on the bus.
    apply('{1'b1, SEL, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd7});
    expect_val("R7 held data", rd, W9);

    // R10: reset in the middle of a read clears the drive.
    @(negedge clk);
    rst_n = 1'b0;
    #1 expect_val("R10 reset mid-read", rdoe, '0);
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
    apply('{1'b0, SEL, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h00, 36'h0, 4'd10});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule